// File: doc/BRIEF.md
# CRC-16 Keystream Stream Cipher

This block XORs a byte stream with a keystream made from a 32-bit key seed. Encryption and decryption are the same operation. The keystream comes in 512-byte blocks. Each block starts from a 16-bit CRC state formed from the current seed, and the seed then steps by one for the next block. Within a block there are sixteen rounds. Each round turns the CRC state into sixteen 16-bit words, which are bit-reversed, complemented and shifted recombinations of that state. The round emits those words as 32 bytes and then folds each word back into the state in turn.

Software writes a seed and a byte offset and pulses start. The offset lets the stream begin partway through: the block index offset/512 is added to the seed, and the first offset mod 512 keystream bytes are discarded. After that, bytes flow through a valid/ready input and a valid/ready output. The XOR path is combinational. The output stalls whenever the next keystream byte is not ready yet.

Top module: `ks16_cipher`

## Requirements
- R1: After reset and until the first start pulse, out_valid_o and in_ready_o stay 0, and input bytes offered in that time are not consumed.
- R2: advance(x) performs 16 iterations of "shift the 16-bit value left by one and, if bit 15 was set before the shift, XOR 0x8005". A block's start state is advance(advance(0x1234 ^ rev(seed[15:0])) ^ rev(seed[31:16])), where rev reverses the 16 bits.
- R3: With s the round start state, r = rev(s), and ~ meaning 16-bit complement, a round's sixteen words w0..w15 are, in this order:
  - w0 = {s[11:4],s[9:2]}
  - w1 = {~r[5:2],s[14:3]}
  - w2 = {r[11:0],~s[11:8]}
  - w3 = {s[12:1],r[5:2]}
  - w4 = r
  - w5 = {~s[7:0],s[15:8]}
  - w6 = {r[11:8],~s[11:0]}
  - w7 = s
  - w8 = {r[14:3],s[14:11]}
  - w9 = ~r
  - w10 = {s[7:0],s[15:8]}
  - w11 = {r[7:0],r[15:8]}
  - w12 = ~s
  - w13 = r
  - w14 = {s[13:2],r[4:1]}
  - w15 = s
- R4: Keystream byte 2k of a round is the low byte of wk and byte 2k+1 is its high byte.
- R5: The next round starts from the state obtained by applying state = advance(state ^ rev(wk)) for k = 0..15 in order.
- R6: A block is 16 rounds (512 bytes). The seed is incremented by one modulo 2^32 after each block's start state is formed, so seed 0xFFFFFFFF is followed by seed 0.
- R7: On start, generation restarts from seed_i + offset_i/512, and the first offset_i mod 512 keystream bytes are discarded without being paired with input.
- R8: Each output byte equals its input byte XOR the matching keystream byte, so a second pass with the same seed and offset restores the plaintext.
- R9: A byte transfers only in a cycle with in_valid_i and out_ready_i both high and a keystream byte available. out_valid_o never rises without in_valid_i, and in_ready_o never rises without out_ready_i. Stalls neither drop nor duplicate a byte.
- R10: A start pulse in the middle of a stream abandons the old stream, and the following bytes use the new seed and offset from keystream byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that loads seed_i and offset_i and restarts the keystream |
| seed_i | input | 32 | Key seed sampled on start |
| offset_i | input | OFFSET_W | Starting byte offset into the keystream, sampled on start |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input byte (plaintext or ciphertext) |
| in_ready_o | output | 1 | Input byte accepted this cycle when high with in_valid_i |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Input byte XOR keystream byte |
| out_ready_i | input | 1 | Downstream accepts the output byte |

## Verification
The hardest conditions to reach from the ports are the ones where the seed arithmetic and the discard count meet:
- an offset whose block index carries the seed past 0xFFFFFFFF;
- an offset that leaves only a few bytes before a block boundary;
- a restart that lands in the middle of a round.

The stimulus reaches each of these by picking the seed and offset directly. Examples are seed 0xFFFFFFFE with offset 1023, an offset of 500 with a 100-byte run, and a start pulse after 40 bytes of an earlier stream.

Both handshake sides are driven from a pseudo-random pattern. This exposes stalls during the skip phase and between rounds.

Every byte is compared with a keystream model written in integer arithmetic in the bench.

// File: rtl/ks16_pkg.sv
package ks16_pkg;

    localparam int WORD_W      = 16;
    localparam int WORDS       = 16;
    localparam int ROUNDS      = 16;
    localparam int RND_BYTES   = 2 * WORDS;
    localparam int BLK_BYTES   = RND_BYTES * ROUNDS;
    localparam int SKIP_W      = $clog2(BLK_BYTES);
    localparam int BIDX_W      = $clog2(RND_BYTES) + 1;
    localparam int UPD_W       = $clog2(WORDS) + 1;
    localparam int RND_W       = $clog2(ROUNDS);
    localparam logic [15:0] POLY = 16'h8005;
    localparam logic [15:0] IV   = 16'h1234;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [WORDS-1:0][WORD_W-1:0] wordset_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_INIT = 2'd1,
        PH_LOAD = 2'd2,
        PH_EMIT = 2'd3
    } phase_t;

    function automatic word_t rev16(input word_t v);
        word_t r;
        for (int i = 0; i < WORD_W; i++) r[i] = v[WORD_W-1-i];
        return r;
    endfunction

    function automatic word_t adv16(input word_t v);
        word_t x;
        x = v;
        for (int i = 0; i < WORD_W; i++) x = {x[14:0], 1'b0} ^ (x[15] ? POLY : 16'h0000);
        return x;
    endfunction

    // One of the sixteen derived words of a round, selected by its position.
    function automatic word_t round_word(input word_t s, input int pos);
        word_t r, ns, nr;
        r  = rev16(s);
        ns = ~s;
        nr = ~r;
        case (pos)
            0:       return {s[11:4], s[9:2]};
            1:       return {nr[5:2], s[14:3]};
            2:       return {r[11:0], ns[11:8]};
            3:       return {s[12:1], r[5:2]};
            4:       return r;
            5:       return {ns[7:0], s[15:8]};
            6:       return {r[11:8], ns[11:0]};
            7:       return s;
            8:       return {r[14:3], s[14:11]};
            9:       return nr;
            10:      return {s[7:0], s[15:8]};
            11:      return {r[7:0], r[15:8]};
            12:      return ns;
            13:      return r;
            14:      return {s[13:2], r[4:1]};
            default: return s;
        endcase
    endfunction

endpackage

// File: rtl/ks16_values.sv
module ks16_values
    import ks16_pkg::*;
(
    input  word_t    state_i,
    output wordset_t words_o
);
    for (genvar g = 0; g < WORDS; g++) begin : g_word
        assign words_o[g] = round_word(state_i, g);
    end
endmodule

// File: rtl/ks16_block_init.sv
module ks16_block_init
    import ks16_pkg::*;
(
    input  logic [31:0] seed_i,
    output word_t       state_o
);
    word_t first;
    always_comb begin
        first   = adv16(IV ^ rev16(seed_i[15:0]));
        state_o = adv16(first ^ rev16(seed_i[31:16]));
    end
endmodule

// File: rtl/ks16_cipher.sv
module ks16_cipher
    import ks16_pkg::*;
#(
    parameter int OFFSET_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [31:0]         seed_i,
    input  logic [OFFSET_W-1:0] offset_i,
    input  logic                in_valid_i,
    input  logic [7:0]          in_data_i,
    output logic                in_ready_o,
    output logic                out_valid_o,
    output logic [7:0]          out_data_o,
    input  logic                out_ready_i
);
    localparam logic [BIDX_W-1:0] BIDX_END = BIDX_W'(RND_BYTES);
    localparam logic [UPD_W-1:0]  UPD_END  = UPD_W'(WORDS);
    localparam logic [RND_W-1:0]  RND_LAST = RND_W'(ROUNDS - 1);

    typedef struct packed {
        phase_t            ph;
        logic [31:0]       seed;
        logic [SKIP_W-1:0] skip;
        word_t             crc;
        wordset_t          rf;
        logic [BIDX_W-1:0] bidx;
        logic [UPD_W-1:0]  upd;
        logic [RND_W-1:0]  rnd;
    } ctl_t;

    ctl_t q, d;

    word_t    blk_state;
    wordset_t round_vals;
    word_t    step_state;
    word_t    cur_word;
    logic     ks_ok;
    logic     fire;

    ks16_block_init u_init (
        .seed_i  (q.seed),
        .state_o (blk_state)
    );

    ks16_values u_vals (
        .state_i (q.crc),
        .words_o (round_vals)
    );

    always_comb begin
        step_state  = adv16(q.crc ^ rev16(q.rf[q.upd[UPD_W-2:0]]));
        cur_word    = q.rf[q.bidx[BIDX_W-2:1]];
        ks_ok       = (q.ph == PH_EMIT) && (q.bidx != BIDX_END) && (q.skip == '0);
        fire        = ks_ok && in_valid_i && out_ready_i;
        out_valid_o = ks_ok && in_valid_i;
        in_ready_o  = ks_ok && out_ready_i;
        out_data_o  = in_data_i ^ (q.bidx[0] ? cur_word[15:8] : cur_word[7:0]);

        d = q;
        case (q.ph)
            PH_INIT: begin
                d.crc  = blk_state;
                d.seed = q.seed + 32'd1;
                d.rnd  = '0;
                d.ph   = PH_LOAD;
            end
            PH_LOAD: begin
                d.rf   = round_vals;
                d.bidx = '0;
                d.upd  = '0;
                d.ph   = PH_EMIT;
            end
            PH_EMIT: begin
                if (q.upd != UPD_END) begin
                    d.crc = step_state;
                    d.upd = q.upd + 1'b1;
                end
                if (q.bidx != BIDX_END) begin
                    if (q.skip != '0) begin
                        d.skip = q.skip - 1'b1;
                        d.bidx = q.bidx + 1'b1;
                    end else if (fire) begin
                        d.bidx = q.bidx + 1'b1;
                    end
                end
                if (q.bidx == BIDX_END && q.upd == UPD_END) begin
                    if (q.rnd == RND_LAST) begin
                        d.ph = PH_INIT;
                    end else begin
                        d.rnd = q.rnd + 1'b1;
                        d.ph  = PH_LOAD;
                    end
                end
            end
            default: ;
        endcase

        if (start_i) begin
            d.ph   = PH_INIT;
            d.seed = seed_i + 32'(offset_i >> SKIP_W);
            d.skip = offset_i[SKIP_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R1: nothing flows before the first start
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_IDLE) |-> (!out_valid_o && !in_ready_o));

    // R7: discarded bytes are never offered to the streams
    a_r7_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_EMIT && q.skip != '0) |-> (!out_valid_o && !in_ready_o));

    // R9: without a transfer the keystream position holds
    a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_EMIT && q.skip == '0 && !start_i && !(in_valid_i && out_ready_i))
        |=> $stable(q.bidx));

    // R10: a start blanks the streams in the following cycle
    a_r10_start_blank: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!out_valid_o && !in_ready_o));

    // R5: the state chain never runs past sixteen steps
    a_r5_upd_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.upd <= UPD_END);

    // R3: a round's words are loaded before its bytes go out
    a_r3_load_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ph == PH_EMIT) |-> ($past(q.ph) == PH_LOAD));

endmodule

// File: tb/ks16_cipher_tb.sv
module ks16_cipher_tb;
    localparam int PERIOD = 10;
    localparam int MAXN   = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] seed_i = '0;
    logic [31:0] offset_i = '0;
    logic        in_valid_i = 1'b0;
    logic [7:0]  in_data_i = '0;
    logic        in_ready_o;
    logic        out_valid_o;
    logic [7:0]  out_data_o;
    logic        out_ready_i = 1'b0;

    int checks = 0;
    int errors = 0;
    logic [15:0] lf = 16'hACE1;

    byte unsigned kse  [MAXN];
    byte unsigned din  [MAXN];
    byte unsigned dout [MAXN];
    byte unsigned keep [MAXN];

    always #(PERIOD/2) clk = ~clk;

    ks16_cipher u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .seed_i(seed_i),
        .offset_i(offset_i), .in_valid_i(in_valid_i), .in_data_i(in_data_i),
        .in_ready_o(in_ready_o), .out_valid_o(out_valid_o), .out_data_o(out_data_o),
        .out_ready_i(out_ready_i)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int unsigned m_adv(input int unsigned v);
        int unsigned x = v;
        for (int i = 0; i < 16; i++)
            x = ((x << 1) ^ (((x & 32'h8000) != 0) ? 32'h8005 : 32'h0)) & 32'hFFFF;
        return x;
    endfunction

    function automatic int unsigned m_rev(input int unsigned v);
        int unsigned r = 0;
        for (int i = 0; i < 16; i++) r |= ((v >> i) & 1) << (15 - i);
        return r;
    endfunction

    task automatic model(input int unsigned sd, input int unsigned off, input int n);
        int unsigned seed = sd + off / 512;
        int skip = int'(off % 512);
        int pos = 0;
        int unsigned st, r, ns, nr;
        int unsigned v [16];
        while (pos < skip + n) begin
            st = m_adv(m_adv(32'h1234 ^ m_rev(seed & 32'hFFFF)) ^ m_rev(seed >> 16));
            seed = seed + 1;
            for (int rd = 0; rd < 16; rd++) begin
                r = m_rev(st); ns = st ^ 32'hFFFF; nr = r ^ 32'hFFFF;
                v[0]  = ((st << 4) & 32'hFF00) | ((st >> 2) & 32'hFF);
                v[1]  = ((nr << 10) & 32'hF000) | ((st >> 3) & 32'hFFF);
                v[2]  = ((r << 4) & 32'hFFF0) | ((ns >> 8) & 32'hF);
                v[3]  = ((st << 3) & 32'hFFF0) | ((r >> 2) & 32'hF);
                v[4]  = r;
                v[5]  = ((ns << 8) | (st >> 8)) & 32'hFFFF;
                v[6]  = ((r << 4) & 32'hF000) | (ns & 32'hFFF);
                v[7]  = st;
                v[8]  = ((r << 1) & 32'hFFF0) | ((st >> 11) & 32'hF);
                v[9]  = nr;
                v[10] = ((st << 8) | (st >> 8)) & 32'hFFFF;
                v[11] = ((r << 8) | (r >> 8)) & 32'hFFFF;
                v[12] = ns;
                v[13] = r;
                v[14] = ((st << 2) & 32'hFFF0) | ((r >> 1) & 32'hF);
                v[15] = st;
                for (int k = 0; k < 16; k++) begin
                    for (int b = 0; b < 2; b++) begin
                        if (pos >= skip && pos - skip < MAXN)
                            kse[pos - skip] = byte'((v[k] >> (8 * b)) & 32'hFF);
                        pos++;
                    end
                end
                for (int k = 0; k < 16; k++) st = m_adv(st ^ m_rev(v[k]));
            end
        end
    endtask

    task automatic run_stream(input int unsigned sd, input int unsigned off, input int n,
                              input int pat, input string req);
        int got = 0;
        int cyc = 0;
        byte unsigned exp;
        model(sd, off, n);
        @(negedge clk);
        start_i = 1'b1; seed_i = sd; offset_i = off; in_valid_i = 1'b0; out_ready_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (got < n && cyc < 20000) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            in_valid_i  = (pat == 0) ? 1'b1 : lf[0];
            out_ready_i = (pat == 0) ? 1'b1 : (lf[3] | lf[7]);
            in_data_i   = din[got];
            #1;
            chk(!(out_valid_o && !in_valid_i), "R9 out_valid without in_valid", out_valid_o, 0);
            chk(!(in_ready_o && !out_ready_i), "R9 in_ready without out_ready", in_ready_o, 0);
            if (out_valid_o && out_ready_i) begin
                exp = din[got] ^ kse[got];
                chk(out_data_o == exp, req, out_data_o, exp);
                dout[got] = out_data_o;
                got++;
            end
            @(negedge clk);
            cyc++;
        end
        in_valid_i = 1'b0;
        chk(got == n, "R9 stream stalled (watchdog)", got, n);
    endtask

    initial begin
        #(PERIOD * 190000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < MAXN; i++) din[i] = byte'((i * 37 + 11) ^ (i >> 3));
        #(PERIOD * 2);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: offered input before any start is neither accepted nor passed on
        in_valid_i = 1'b1; out_ready_i = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk); #1;
            chk(!in_ready_o && !out_valid_o, "R1 quiet before start",
                {in_ready_o, out_valid_o}, 0);
        end
        in_valid_i = 1'b0;

        // R2 R3 R4 R5 R6: zero seed, full block plus part of the next
        run_stream(32'h0, 0, 600, 0, "R2 R3 R4 R5 R6 seed0 data");
        // R7: offset near a block boundary, random handshakes
        run_stream(32'h12345678, 500, 100, 1, "R7 offset 500 data");
        // R7: offset with block index 2 and skip 6
        run_stream(32'hCAFEF00D, 1030, 200, 1, "R7 offset 1030 data");
        // R6: seed wraps from 0xFFFFFFFF to 0
        run_stream(32'hFFFFFFFF, 0, 530, 1, "R6 seed wrap data");
        // R6 R7: block index carries seed to 0xFFFFFFFF, skip 511, then wraps
        run_stream(32'hFFFFFFFE, 1023, 40, 0, "R6 R7 carry offset data");

        // R8: encrypt then decrypt restores the plaintext
        for (int i = 0; i < 300; i++) keep[i] = din[i];
        run_stream(32'h0BADBEEF, 77, 300, 1, "R8 encrypt data");
        for (int i = 0; i < 300; i++) din[i] = dout[i];
        run_stream(32'h0BADBEEF, 77, 300, 1, "R8 decrypt data");
        for (int i = 0; i < 300; i++) chk(dout[i] == keep[i], "R8 round trip", dout[i], keep[i]);
        for (int i = 0; i < 300; i++) din[i] = keep[i];

        // R10: restart mid-round, then a fresh stream from byte 0
        run_stream(32'h55AA55AA, 3, 40, 1, "R10 first stream data");
        run_stream(32'h31113111, 0, 70, 1, "R10 restarted stream data");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule